// File: doc/BRIEF.md
# Reloadable Watchdog Timer Unit

This block is a 16-bit supervisory timer for a small microcontroller subsystem. An up-counter advances on a tick from a selectable prescaler and must be serviced by software before it passes its maximum value. The count is two chained 8-bit stages. A service strobe loads the upper stage from a programmable reload byte and clears the lower stage.

When the counter overflows, the active-low overflow pulse always fires. Two things can follow. With the reset disabled, the counter reloads itself, so the unit works as a periodic interrupt timer. With the reset enabled, which is the default, the unit raises a one-cycle reset request, returns itself to its power-on settings and records that a watchdog reset took place. A simple register bus reads the live count and reads and writes the control word. A global enable input freezes the whole unit.

Top module: `wdt_unit`

## Requirements
- R1: After `por_n` is released, the count reads 0x0000, the control word reads 0x0000, `ovf_n` is 1 and `wdt_rst_req` is 0.
- R2: A service strobe (`svc` high for one cycle while `glob_en` is 1) loads the count with {reload byte, 0x00} at the next edge and restarts the prescaler.
- R3: Control bit 0 (source select) and bit 1 (prescale select) set the tick divisor: 00 gives 2, bit 1 alone gives 4, bit 0 alone gives 128, both give 256 clock cycles per count step.
- R4: After a service with reload R, the count reads R*256 + floor(n/D) n cycles later, with the carry from the lower byte passing into the upper byte.
- R5: With control bit 2 (reset disable) at 1, an overflow reloads the count with {reload byte, 0x00}. The overflow comes exactly 256*(256-R)*D cycles after a service.
- R6: Every overflow drives `ovf_n` low for exactly one cycle, in the cycle after the overflowing edge, in both modes.
- R7: With bit 2 at 0, an overflow drives `wdt_rst_req` high for one cycle. In that same cycle the count is 0x0000 and the control word returns to its defaults with flag bit 3 set, so it reads 0x0008.
- R8: Flag bit 3 keeps its value through a watchdog reset, ignores bus writes, and is cleared only by `por_n`.
- R9: `bus_addr` 0 selects the read-only count, and writes to it have no effect. `bus_addr` 1 selects the control word: reload byte in bits 15:8, bits 7:4 read as 0, and bits 2:0 are writable.
- R10: While `glob_en` is 0, the count holds its value, service strobes are ignored, and no overflow or reset is produced.
- R11: A service strobe in the same cycle as an overflow wins: the count is reloaded from the service value, and neither `ovf_n` nor `wdt_rst_req` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| glob_en | input | 1 | Global enable; 0 freezes the unit |
| svc | input | 1 | Service strobe, one cycle per service |
| bus_addr | input | 1 | Register select: 0 count, 1 control |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| ovf_n | output | 1 | Active-low one-cycle overflow pulse |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The bench runs every pair of source select and prescale select values, each with reload 0xFF. It compares the count against R*256 + floor(n/D) on every cycle up to and past the overflow. This sweep tells the four divisors apart, and it also catches an off-by-one in the carry or in the overflow position. Separate runs cover three cases: a strobe that lands exactly on the overflow cycle, an overflow with the reset enabled, and a frozen unit receiving service and count writes. These separate service priority, reload on overflow and reset on overflow from one another, and they show the flag holding and being cleared.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned HALF_W = 8;
    localparam int unsigned NSTAGE = 2;
    localparam int unsigned CNT_W  = HALF_W * NSTAGE;

    // control word bit positions seen on the bus
    localparam int unsigned B_SRC  = 0;
    localparam int unsigned B_PRE  = 1;
    localparam int unsigned B_RDIS = 2;
    localparam int unsigned B_FLAG = 3;
    localparam int unsigned B_RLD  = CNT_W - HALF_W;

    typedef struct packed {
        logic [HALF_W-1:0] reload;
        logic              rst_dis;
        logic              pre_sel;
        logic              src_sel;
    } wdt_ctl_t;

    typedef struct packed {
        wdt_ctl_t ctl;
        logic     flag;
        logic     ovf_n;
        logic     rst_req;
    } wdt_state_t;

    localparam wdt_ctl_t   CTL_DEF = '0;
    localparam wdt_state_t ST_POR  = '{ctl: CTL_DEF, flag: 1'b0, ovf_n: 1'b1, rst_req: 1'b0};
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned DIV_A = 2,
    parameter int unsigned DIV_B = 4,
    parameter int unsigned DIV_C = 128,
    parameter int unsigned DIV_D = 256,
    parameter int unsigned PW    = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic en_i,
    input  logic clr_i,
    input  logic src_sel_i,
    input  logic pre_sel_i,
    output logic tick_o
);
    logic [PW-1:0] cnt_d, cnt_q;
    logic [PW-1:0] lim;

    always_comb begin
        unique case ({src_sel_i, pre_sel_i})
            2'b00:   lim = PW'(DIV_A - 1);
            2'b01:   lim = PW'(DIV_B - 1);
            2'b10:   lim = PW'(DIV_C - 1);
            default: lim = PW'(DIV_D - 1);
        endcase
        // >= so that a divisor shrunk mid-count still wraps at once
        tick_o = en_i && (cnt_q >= lim);
        cnt_d  = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i) begin
            cnt_d = tick_o ? '0 : cnt_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         clr_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_i,
    output logic [W-1:0] val_o,
    output logic         carry_o
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        carry_o = inc_i && (&val_q);
        val_d   = val_q;
        if (clr_i)       val_d = '0;
        else if (load_i) val_d = load_val_i;
        else if (inc_i)  val_d = val_q + W'(1);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val_o = val_q;
endmodule

// File: rtl/wdt_unit.sv
module wdt_unit #(
    parameter int unsigned DIV_FAST0 = 2,
    parameter int unsigned DIV_FAST1 = 4,
    parameter int unsigned DIV_SLOW0 = 128,
    parameter int unsigned DIV_SLOW1 = 256
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     glob_en,
    input  logic                     svc,
    input  logic                     bus_addr,
    input  logic                     bus_wr,
    input  logic [wdt_pkg::CNT_W-1:0] bus_wdata,
    output logic [wdt_pkg::CNT_W-1:0] bus_rdata,
    output logic                     ovf_n,
    output logic                     wdt_rst_req
);
    import wdt_pkg::*;

    localparam int unsigned PRE_W = $clog2(DIV_SLOW1);

    wdt_state_t st_d, st_q;

    logic              tick;
    logic              svc_ok, ovf_hit, wdt_fire, reload_now;
    logic [NSTAGE:0]   chain;
    logic [HALF_W-1:0] half_val [NSTAGE];
    logic [CNT_W-1:0]  count_w;
    logic              unused_wbits;

    assign unused_wbits = ^{bus_wdata[B_RLD-1:B_FLAG]};

    wdt_prescaler #(
        .DIV_A(DIV_FAST0), .DIV_B(DIV_FAST1),
        .DIV_C(DIV_SLOW0), .DIV_D(DIV_SLOW1), .PW(PRE_W)
    ) u_pre (
        .clk       (clk),
        .por_n     (por_n),
        .en_i      (glob_en),
        .clr_i     (svc_ok || wdt_fire),
        .src_sel_i (st_q.ctl.src_sel),
        .pre_sel_i (st_q.ctl.pre_sel),
        .tick_o    (tick)
    );

    assign chain[0] = tick;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        wdt_stage #(.W(HALF_W)) u_stage (
            .clk        (clk),
            .por_n      (por_n),
            .clr_i      (wdt_fire),
            .load_i     (reload_now),
            .load_val_i ((g == NSTAGE - 1) ? st_q.ctl.reload : HALF_W'(0)),
            .inc_i      (chain[g]),
            .val_o      (half_val[g]),
            .carry_o    (chain[g+1])
        );
    end

    always_comb begin
        count_w = '0;
        for (int i = 0; i < NSTAGE; i++) begin
            count_w[i*HALF_W +: HALF_W] = half_val[i];
        end
    end

    always_comb begin
        svc_ok     = svc && glob_en;
        ovf_hit    = chain[NSTAGE] && !svc_ok;
        wdt_fire   = ovf_hit && !st_q.ctl.rst_dis;
        reload_now = svc_ok || (ovf_hit && st_q.ctl.rst_dis);

        st_d         = st_q;
        st_d.ovf_n   = !ovf_hit;
        st_d.rst_req = wdt_fire;
        if (bus_wr && bus_addr) begin
            st_d.ctl.reload  = bus_wdata[B_RLD +: HALF_W];
            st_d.ctl.rst_dis = bus_wdata[B_RDIS];
            st_d.ctl.pre_sel = bus_wdata[B_PRE];
            st_d.ctl.src_sel = bus_wdata[B_SRC];
        end
        if (wdt_fire) begin
            st_d.ctl  = CTL_DEF;
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= ST_POR;
        else        st_q <= st_d;
    end

    always_comb begin
        if (bus_addr) begin
            bus_rdata         = '0;
            bus_rdata[B_RLD +: HALF_W] = st_q.ctl.reload;
            bus_rdata[B_FLAG] = st_q.flag;
            bus_rdata[B_RDIS] = st_q.ctl.rst_dis;
            bus_rdata[B_PRE]  = st_q.ctl.pre_sel;
            bus_rdata[B_SRC]  = st_q.ctl.src_sel;
        end else begin
            bus_rdata = count_w;
        end
    end

    assign ovf_n       = st_q.ovf_n;
    assign wdt_rst_req = st_q.rst_req;
endmodule

// File: rtl/wdt_unit_chk.sv
module wdt_unit_chk (
    input logic                        clk,
    input logic                        por_n,
    input logic                        glob_en,
    input logic                        svc,
    input logic                        ovf_n,
    input logic                        wdt_rst_req,
    input logic [wdt_pkg::CNT_W-1:0]   count,
    input logic [wdt_pkg::HALF_W-1:0]  reload,
    input logic                        flag
);
    // R6
    ovf_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        !ovf_n |=> ovf_n);

    // R7
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_req |=> !wdt_rst_req);

    // R7
    rst_with_ovf_chk: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_req |-> (!ovf_n && flag && count == '0));

    // R2
    svc_load_chk: assert property (@(posedge clk) disable iff (!por_n)
        (svc && glob_en) |=> count == {$past(reload), {wdt_pkg::HALF_W{1'b0}}});

    // R11
    svc_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
        (svc && glob_en) |=> (ovf_n && !wdt_rst_req));

    // R10
    frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
        !glob_en |=> ($stable(count) && ovf_n && !wdt_rst_req));
endmodule

bind wdt_unit wdt_unit_chk u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .glob_en     (glob_en),
    .svc         (svc),
    .ovf_n       (ovf_n),
    .wdt_rst_req (wdt_rst_req),
    .count       (count_w),
    .reload      (st_q.ctl.reload),
    .flag        (st_q.flag)
);

// File: tb/wdt_unit_tb.sv
module wdt_unit_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        glob_en = 1'b1;
    logic        svc = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ovf_n;
    logic        wdt_rst_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wdt_unit u_dut (
        .clk(clk), .por_n(por_n), .glob_en(glob_en), .svc(svc),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ovf_n(ovf_n), .wdt_rst_req(wdt_rst_req)
    );

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic service();
        svc = 1'b1;
        step(1);
        svc = 1'b0;
    endtask

    function automatic int div_of(input int cfg);
        case (cfg)
            0: return 2;
            1: return 4;
            2: return 128;
            default: return 256;
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, c0, e, fa, fe;
        int d, span, bad, badov;

        repeat (3) @(posedge clk);
        #1 por_n = 1'b1;
        // R1 reset state
        rd(0, v); chk("R1 count after reset", v, 16'h0000);
        rd(1, v); chk("R1 control after reset", v, 16'h0000);
        chk("R1 ovf_n after reset", ovf_n, 1'b1);
        chk("R1 rst_req after reset", wdt_rst_req, 1'b0);

        // R10 frozen unit, R9 count writes ignored
        glob_en = 1'b0;
        step(1);
        rd(0, c0);
        bus_write(0, 16'h1234);
        rd(0, v); chk("R9 count write ignored", v, c0);
        service();
        step(10);
        rd(0, v); chk("R10 frozen count and ignored service", v, c0);
        chk("R10 no overflow while frozen", ovf_n, 1'b1);
        glob_en = 1'b1;

        // R9 control layout, flag write ignored (R8)
        bus_write(1, 16'hA5FF);
        rd(1, v); chk("R9 R8 control readback", v, 16'hA507);

        // R3 R4 R5 R6 sweep over all divisor settings
        for (int cfg = 0; cfg < 4; cfg++) begin
            d = div_of(cfg);
            span = 256 * d;
            bad = 0; badov = 0; fa = '0; fe = '0;
            bus_write(1, 16'hFF04 | 16'((cfg >> 1) & 1) | 16'((cfg & 1) << 1));
            service();
            rd(0, v); chk("R2 service loads reload byte", v, 16'hFF00);
            for (int n = 1; n <= span; n++) begin
                step(1);
                rd(0, v);
                e = (n < span) ? 16'(16'hFF00 + n / d) : 16'hFF00;
                if (v !== e) begin
                    if (bad == 0) begin fa = v; fe = e; end
                    bad++;
                end
                if (ovf_n !== ((n == span) ? 1'b0 : 1'b1)) badov++;
            end
            chk($sformatf("R3 R4 R5 count trajectory cfg %0d", cfg), fa, fe);
            chk($sformatf("R6 overflow pulse position cfg %0d", cfg), badov, 0);
            chk($sformatf("R5 no reset when disabled cfg %0d", cfg), wdt_rst_req, 1'b0);
            step(1);
            chk($sformatf("R6 pulse lasts one cycle cfg %0d", cfg), ovf_n, 1'b1);
        end

        // R11 service on the overflow cycle, reset enabled
        bus_write(1, 16'hFF00);
        service();
        step(511);
        rd(0, v); chk("R11 count at top before overflow", v, 16'hFFFF);
        svc = 1'b1;
        step(1);
        svc = 1'b0;
        rd(0, v); chk("R11 service wins count", v, 16'hFF00);
        chk("R11 no ovf pulse", ovf_n, 1'b1);
        chk("R11 no reset", wdt_rst_req, 1'b0);

        // R7 watchdog reset on overflow
        service();
        step(511);
        chk("R7 no reset before overflow", wdt_rst_req, 1'b0);
        step(1);
        chk("R7 reset request", wdt_rst_req, 1'b1);
        chk("R6 ovf pulse in reset mode", ovf_n, 1'b0);
        rd(0, v); chk("R7 count cleared", v, 16'h0000);
        rd(1, v); chk("R7 control defaults with flag", v, 16'h0008);
        step(1);
        chk("R7 reset lasts one cycle", wdt_rst_req, 1'b0);
        rd(0, v); chk("R7 counting restarts from zero", v, 16'h0000);

        // R8 flag survives writes, cleared by power-on reset
        bus_write(1, 16'h0004);
        rd(1, v); chk("R8 flag ignores write", v, 16'h000C);
        por_n = 1'b0;
        step(1);
        por_n = 1'b1;
        step(1);
        rd(1, v); chk("R8 flag cleared by por", v, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule